// File: doc/BRIEF.md
# CAN Interrupt Identifier Priority Register

This block turns a set of pending interrupt sources of a CAN controller into one 16-bit identifier code and one interrupt request line for the processor. The sources are a status-change flag and up to 32 message objects, each of which has a pending bit. The identifier always names the single most urgent source that is pending. The status source outranks every message object. Among the objects, a lower object number wins.

The identifier is a register. It follows the pending inputs with one cycle of latency. When a more urgent source arrives, its code replaces the code on display. When the source on display clears, the next most urgent pending source takes its place one cycle later. The interrupt line combines the registered identifier with a global enable.

Setting and clearing the pending bits happens outside this block. Software clears an object's pending bit in the message store. Reading the status register clears the status flag.

Top module: `can_intid_top`

## Requirements
- R1: While reset is asserted and after it is released with nothing pending, the identifier is 0x0000 and the interrupt line is low.
- R2: If the status flag is pending in a cycle, the identifier is 0x8000 after the next clock edge, whatever object bits are pending, including bits that rise in the same cycle.
- R3: With the status flag clear and some object bits set, the identifier after the next edge is k+1, where k is the lowest set index of the object vector (bit 0 is object 1 and gives 0x0001; bit 31 is object 32 and gives 0x0020).
- R4: With no source pending, the identifier is 0x0000 after the next edge.
- R5: A more urgent source that becomes pending while a less urgent code is shown replaces that code after one edge.
- R6: When the source on display clears, the identifier shows the next most urgent pending source, or 0x0000, after one edge.
- R7: The interrupt line is high exactly when the enable input is 1 and the registered identifier is nonzero. It follows the enable input with no clock delay.
- R8: The identifier only ever takes the values 0x0000, 0x0001 to 0x0020, or 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| obj_pend_i | input | 32 | Per-object pending bits, bit k is object k+1 |
| stat_pend_i | input | 1 | Status-change interrupt pending |
| int_en_i | input | 1 | Global interrupt enable |
| int_id_o | output | 16 | Registered interrupt identifier code |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the pending inputs are stable and known at each rising edge. They make no assumption about how the pending bits rise or fall, so any combination of bits may appear in any cycle. The stimulus changes inputs only at falling edges. It combines directed sequences with pseudo-random vectors. The directed sequences cover the preemption and clearing orders and the case where the status flag and an object bit rise together. The random vectors are kept sparse so that high-numbered objects also win sometimes.

// File: rtl/can_intid_pkg.sv
package can_intid_pkg;
  localparam int unsigned CODE_W = 16;
  localparam logic [CODE_W-1:0] CODE_NONE = 16'h0000;
  localparam logic [CODE_W-1:0] CODE_STAT = 16'h8000;
endpackage

// File: rtl/can_intid_obj_enc.sv
// Lowest set index wins; code is index+1.
module can_intid_obj_enc #(
  parameter int unsigned NUM_OBJ = 32
) (
  input  logic [NUM_OBJ-1:0]                   pend_i,
  output logic                                 any_o,
  output logic [can_intid_pkg::CODE_W-1:0]     code_o
);
  import can_intid_pkg::*;

  logic [NUM_OBJ-1:0] hit;
  logic [NUM_OBJ-1:0] seen;
  logic [CODE_W-1:0]  term [NUM_OBJ];

  for (genvar k = 0; k < NUM_OBJ; k++) begin : g_bit
    if (k == 0) begin : g_first
      assign hit[k]  = pend_i[k];
      assign seen[k] = pend_i[k];
    end else begin : g_rest
      assign hit[k]  = pend_i[k] & ~seen[k-1];
      assign seen[k] = seen[k-1] | pend_i[k];
    end
    assign term[k] = hit[k] ? CODE_W'(k + 1) : CODE_NONE;
  end

  always_comb begin
    code_o = CODE_NONE;
    for (int unsigned k = 0; k < NUM_OBJ; k++) code_o = code_o | term[k];
  end

  assign any_o = seen[NUM_OBJ-1];
endmodule

// File: rtl/can_intid_reg.sv
module can_intid_reg (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             stat_pend_i,
  input  logic                             obj_any_i,
  input  logic [can_intid_pkg::CODE_W-1:0] obj_code_i,
  output logic [can_intid_pkg::CODE_W-1:0] id_q_o
);
  import can_intid_pkg::*;

  logic [CODE_W-1:0] id_d;

  always_comb begin
    if (stat_pend_i)    id_d = CODE_STAT;
    else if (obj_any_i) id_d = obj_code_i;
    else                id_d = CODE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) id_q_o <= CODE_NONE;
    else         id_q_o <= id_d;
  end
endmodule

// File: rtl/can_intid_irq.sv
module can_intid_irq (
  input  logic                             en_i,
  input  logic [can_intid_pkg::CODE_W-1:0] id_i,
  output logic                             irq_o
);
  assign irq_o = en_i & (|id_i);
endmodule

// File: rtl/can_intid_top.sv
module can_intid_top #(
  parameter int unsigned NUM_OBJ = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_OBJ-1:0]               obj_pend_i,
  input  logic                             stat_pend_i,
  input  logic                             int_en_i,
  output logic [can_intid_pkg::CODE_W-1:0] int_id_o,
  output logic                             irq_o
);
  import can_intid_pkg::*;

  logic              obj_any;
  logic [CODE_W-1:0] obj_code;

  can_intid_obj_enc #(.NUM_OBJ(NUM_OBJ)) u_enc (
    .pend_i (obj_pend_i),
    .any_o  (obj_any),
    .code_o (obj_code)
  );

  can_intid_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stat_pend_i (stat_pend_i),
    .obj_any_i   (obj_any),
    .obj_code_i  (obj_code),
    .id_q_o      (int_id_o)
  );

  can_intid_irq u_irq (
    .en_i  (int_en_i),
    .id_i  (int_id_o),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/can_intid_chk.sv
module can_intid_chk #(
  parameter int unsigned NUM_OBJ = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_OBJ-1:0] obj_pend_i,
  input logic               stat_pend_i,
  input logic               int_en_i,
  input logic [15:0]        int_id_o,
  input logic               irq_o
);
  // R8
  a_r8_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_id_o == 16'h0000) || (int_id_o == 16'h8000) ||
    (int_id_o >= 16'd1 && int_id_o <= 16'(NUM_OBJ)));

  // R2
  a_r2_status_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_pend_i |=> int_id_o == 16'h8000);

  // R4
  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_pend_i && obj_pend_i == '0) |=> int_id_o == 16'h0000);

  // R3: shown object is pending and no lower one is
  a_r3_lowest_obj: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_pend_i && obj_pend_i != '0) |=>
      (int_id_o >= 16'd1 && int_id_o <= 16'(NUM_OBJ) &&
       (($past(obj_pend_i) >> (int_id_o - 16'd1)) & NUM_OBJ'(1)) == NUM_OBJ'(1) &&
       ($past(obj_pend_i) & ((NUM_OBJ'(1) << (int_id_o - 16'd1)) - NUM_OBJ'(1))) == '0));

  // R7
  a_r7_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_en_i || int_id_o == 16'h0000) |-> !irq_o);
  a_r7_irq_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_en_i && int_id_o != 16'h0000) |-> irq_o);
endmodule

bind can_intid_top can_intid_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .obj_pend_i  (obj_pend_i),
  .stat_pend_i (stat_pend_i),
  .int_en_i    (int_en_i),
  .int_id_o    (int_id_o),
  .irq_o       (irq_o)
);

// File: tb/sim_can_intid_top.sv
`timescale 1ns/1ps
module sim_can_intid_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] obj = '0;
  logic        stat = 1'b0;
  logic        en = 1'b0;
  logic [15:0] id;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int exp_id = 0;

  always #4 clk = ~clk;

  can_intid_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .obj_pend_i(obj), .stat_pend_i(stat),
    .int_en_i(en), .int_id_o(id), .irq_o(irq)
  );

  // reference: status first, then lowest object number
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_id <= 0;
    else begin
      int e;
      e = 0;
      if (stat) e = 32'h8000;
      else
        for (int k = 31; k >= 0; k--) if (obj[k]) e = k + 1;
      exp_id <= e;
    end
  end

  task automatic check(string tag);
    int ei;
    ei = (en && exp_id != 0) ? 1 : 0;
    checks++;
    if (int'(id) != exp_id) begin
      errors++;
      $display("FAIL %s id: actual %h expected %h", tag, id, exp_id);
    end
    checks++;
    if (int'(irq) != ei) begin
      errors++;
      $display("FAIL %s irq: actual %0d expected %0d", tag, irq, ei);
    end
  endtask

  task automatic apply(bit s, logic [31:0] o, bit e, string tag);
    stat = s; obj = o; en = e;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    apply(0, 32'h0, 1, "R4");
    apply(0, 32'h1, 1, "R3");
    apply(0, 32'h8000_0000, 1, "R3");
    apply(0, 32'h0000_0220, 1, "R3");
    apply(0, 32'h0, 1, "R4");
    apply(0, 32'h0000_0200, 1, "R3");
    apply(0, 32'h0000_0204, 1, "R5");
    apply(1, 32'h0000_0204, 1, "R5");
    apply(0, 32'h0000_0204, 1, "R6");
    apply(0, 32'h0000_0200, 1, "R6");
    apply(0, 32'h0, 1, "R6");
    apply(1, 32'h0000_0001, 1, "R2");
    apply(1, 32'hFFFF_FFFF, 1, "R2");
    apply(0, 32'h8000_0000, 0, "R7");
    apply(0, 32'h8000_0000, 1, "R7");
    apply(0, 32'h0, 1, "R7");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v;
      v = $urandom() & $urandom() & $urandom();
      apply(($urandom() % 5) == 0, v, $urandom() % 4 != 0, "R8");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule